// File: doc/BRIEF.md
# Split-Tag Direct-Mapped Address Translation Buffer

This block maps virtual addresses to physical addresses for three kinds of access: instruction fetch, data load and data store. Pages are 4 KiB, so the low 12 address bits pass through untouched. The page bits above them select one slot of a direct-mapped table.

The table has one shared array of physical page numbers. Three tag arrays guard it, one per access kind, and each has its own valid bit per slot. A hit for one kind says nothing about the other kinds. A tag mismatch is reported as a miss on the response. The response carries the virtual address and the kind, so an external page walker can return a page number on the refill port.

A load or store whose address is not a multiple of its size raises a misalign trap instead of a lookup. That address is latched as the fault address. Writing the page-table base stores the value with its offset bits cleared and empties the whole table.

Requests and responses use valid/ready handshakes:
- A request is taken on a clock edge where both `req_valid` and `req_ready` are high.
- Its response is visible from the next cycle.
- `req_ready` is low while an unaccepted response is pending, and in any cycle that carries a refill or a page-table-base write.
- An offered response holds every field steady until `rsp_ready` takes it.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, `rsp_valid`, `ptbr` and `fault_vaddr` are 0, `req_ready` is 1, and every slot of every tag array is invalid, so every aligned lookup misses.
- R2: `req_ready` is 0 in any cycle with `refill_valid` or `ptbr_we` high, or with `rsp_valid` high and `rsp_ready` low. A response left untaken keeps `rsp_valid` and all its fields unchanged.
- R3: The slot index is `vaddr[12 +: log2(ENTRIES)]`. The stored tag is every address bit above the index. A lookup hits only when the selected kind's slot is valid and its tag matches.
- R4: On a hit, `rsp_paddr` is the slot's page number followed by `vaddr[11:0]`.
- R5: Each response sets exactly one of `rsp_hit`, `rsp_miss`, `rsp_ld_misalign` and `rsp_st_misalign`. On a miss `rsp_paddr` is 0, and `rsp_vaddr` and `rsp_kind` repeat the request.
- R6: Kind encoding: 0 is fetch, 1 is load, 2 is store, and 3 is treated as load. A refill of kind K makes later kind-K lookups of that page hit.
- R7: A refill writes the shared page number, sets the tag of its own kind, and invalidates the other two kinds' tags at that slot.
- R8: Size encoding: the access is 2^`req_size` bytes. A load or store whose `vaddr[2:0]` has any of the low `req_size` bits set returns the load- or store-misalign flag, with `rsp_paddr` 0 and no lookup. Fetches never raise a misalign trap.
- R9: `fault_vaddr` takes the address of each misaligned request and keeps it until the next misaligned request.
- R10: A `ptbr_we` cycle sets `ptbr` to `ptbr_wdata` with its low 12 bits cleared and invalidates every slot of all three tag arrays.
- R11: Two pages with the same index share one slot per kind. Refilling one of them evicts the other for that kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_vaddr | input | ADDR_W | Virtual address |
| req_kind | input | 2 | Access kind (0 fetch, 1 load, 2 store, 3 load) |
| req_size | input | 2 | log2 of access size in bytes |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Response taken |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Translation absent, refill needed |
| rsp_ld_misalign | output | 1 | Load misalign trap |
| rsp_st_misalign | output | 1 | Store misalign trap |
| rsp_paddr | output | PA_W | Physical address on hit, else 0 |
| rsp_vaddr | output | ADDR_W | Virtual address of the request |
| rsp_kind | output | 2 | Kind of the request |
| refill_valid | input | 1 | Refill write this cycle |
| refill_vpn | input | ADDR_W-12 | Virtual page number being filled |
| refill_kind | input | 2 | Kind whose tag is filled |
| refill_ppn | input | PA_W-12 | Physical page number |
| ptbr_we | input | 1 | Page-table-base write and flush |
| ptbr_wdata | input | PA_W | Page-table-base value |
| ptbr | output | PA_W | Page-table-base register |
| fault_vaddr | output | ADDR_W | Last misaligned address |

## Verification
The bench refills every slot for every kind and then checks the same page under all three kinds. A design that shared one tag array would hit where it should miss, and one that failed to clear the other kinds' tags would return a stale frame. It sweeps every size against every low-address pattern for each kind. A wrong mask, or a fetch that traps, shows up as a wrong flag or a wrong fault address. Same-index pages that evict each other, a flush after a full table, and responses held under back-pressure catch index/tag slicing errors, incomplete flushes and responses that drift before they are taken.

// File: rtl/tlb_xlate_pkg.sv
package tlb_xlate_pkg;

  localparam int NUM_WAYS = 3;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_LOAD  = 2'd1,
    KIND_STORE = 2'd2,
    KIND_LOADX = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic hit;
    logic miss;
    logic ld_mis;
    logic st_mis;
  } rsp_flags_t;

  // Kind code to tag-array number: 0 fetch, 1 load, 2 store.
  function automatic logic [1:0] kind_to_way(input logic [1:0] kind);
    case (kind)
      KIND_FETCH: kind_to_way = 2'd0;
      KIND_STORE: kind_to_way = 2'd2;
      default:    kind_to_way = 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/tlb_misalign_chk.sv
module tlb_misalign_chk
  import tlb_xlate_pkg::*;
(
  input  logic [2:0] addr_lo,
  input  logic [1:0] kind,
  input  logic [1:0] size,
  output logic       ld_trap,
  output logic       st_trap
);

  logic [2:0] size_mask;
  logic       off;
  logic [1:0] way;

  always_comb begin
    case (size)
      2'd0:    size_mask = 3'b000;
      2'd1:    size_mask = 3'b001;
      2'd2:    size_mask = 3'b011;
      default: size_mask = 3'b111;
    endcase
    off     = |(addr_lo & size_mask);
    way     = kind_to_way(kind);
    ld_trap = off && (way == 2'd1);
    st_trap = off && (way == 2'd2);
  end

endmodule

// File: rtl/tlb_tag_way.sv
module tlb_tag_way #(
  parameter int IDX_BITS = 8,
  parameter int TAG_W    = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                wr_en,
  input  logic                inv_en,
  input  logic [IDX_BITS-1:0] wr_idx,
  input  logic [TAG_W-1:0]    wr_tag,
  input  logic [IDX_BITS-1:0] rd_idx,
  input  logic [TAG_W-1:0]    rd_tag,
  output logic                rd_hit
);

  localparam int ENTRIES = 1 << IDX_BITS;

  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (flush) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end else if (inv_en) begin
      valid_q[wr_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  assign rd_hit = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);

  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));

  assert_fill_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> valid_q[$past(wr_idx)]);

  assert_other_kinds_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && !flush) |=> !valid_q[$past(wr_idx)]);

endmodule

// File: rtl/tlb_page_store.sv
module tlb_page_store #(
  parameter int IDX_BITS = 8,
  parameter int PPN_W    = 20
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [IDX_BITS-1:0] wr_idx,
  input  logic [PPN_W-1:0]    wr_ppn,
  input  logic [IDX_BITS-1:0] rd_idx,
  output logic [PPN_W-1:0]    rd_ppn
);

  localparam int ENTRIES = 1 << IDX_BITS;

  logic [PPN_W-1:0] ppn_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) ppn_q[wr_idx] <= wr_ppn;
  end

  assign rd_ppn = ppn_q[rd_idx];

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_xlate_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES   = 256
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_vaddr,
  input  logic [1:0]            req_kind,
  input  logic [1:0]            req_size,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic                  rsp_hit,
  output logic                  rsp_miss,
  output logic                  rsp_ld_misalign,
  output logic                  rsp_st_misalign,
  output logic [PA_W-1:0]       rsp_paddr,
  output logic [ADDR_W-1:0]     rsp_vaddr,
  output logic [1:0]            rsp_kind,
  input  logic                  refill_valid,
  input  logic [ADDR_W-PAGE_BITS-1:0] refill_vpn,
  input  logic [1:0]            refill_kind,
  input  logic [PA_W-PAGE_BITS-1:0]   refill_ppn,
  input  logic                  ptbr_we,
  input  logic [PA_W-1:0]       ptbr_wdata,
  output logic [PA_W-1:0]       ptbr,
  output logic [ADDR_W-1:0]     fault_vaddr
);

  localparam int IDX_BITS = $clog2(ENTRIES);
  localparam int VPN_W    = ADDR_W - PAGE_BITS;
  localparam int TAG_W    = VPN_W - IDX_BITS;
  localparam int PPN_W    = PA_W - PAGE_BITS;
  localparam logic [PA_W-1:0] OFF_MASK = PA_W'((1 << PAGE_BITS) - 1);

  // Request side
  logic                accept;
  logic [IDX_BITS-1:0] lk_idx;
  logic [TAG_W-1:0]    lk_tag;
  logic [1:0]          lk_way;
  logic [NUM_WAYS-1:0] way_hit;
  logic                sel_hit;
  logic                ld_trap, st_trap;
  logic [PPN_W-1:0]    lk_ppn;

  // Refill side
  logic [IDX_BITS-1:0] rf_idx;
  logic [TAG_W-1:0]    rf_tag;
  logic [1:0]          rf_way;

  // Response registers
  logic                rsp_valid_q;
  rsp_flags_t          flags_q;
  logic [PA_W-1:0]     paddr_q;
  logic [ADDR_W-1:0]   vaddr_q;
  logic [1:0]          kind_q;
  logic [PA_W-1:0]     ptbr_q;
  logic [ADDR_W-1:0]   fault_q;

  assign req_ready = (!rsp_valid_q || rsp_ready) && !refill_valid && !ptbr_we;
  assign accept    = req_valid && req_ready;

  assign lk_idx = req_vaddr[PAGE_BITS +: IDX_BITS];
  assign lk_tag = req_vaddr[ADDR_W-1 -: TAG_W];
  assign lk_way = kind_to_way(req_kind);

  assign rf_idx = refill_vpn[IDX_BITS-1:0];
  assign rf_tag = refill_vpn[VPN_W-1 -: TAG_W];
  assign rf_way = kind_to_way(refill_kind);

  tlb_misalign_chk u_align (
    .addr_lo (req_vaddr[2:0]),
    .kind    (req_kind),
    .size    (req_size),
    .ld_trap (ld_trap),
    .st_trap (st_trap)
  );

  generate
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      tlb_tag_way #(
        .IDX_BITS (IDX_BITS),
        .TAG_W    (TAG_W)
      ) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (ptbr_we),
        .wr_en  (refill_valid && (rf_way == 2'(w))),
        .inv_en (refill_valid && (rf_way != 2'(w))),
        .wr_idx (rf_idx),
        .wr_tag (rf_tag),
        .rd_idx (lk_idx),
        .rd_tag (lk_tag),
        .rd_hit (way_hit[w])
      );
    end
  endgenerate

  tlb_page_store #(
    .IDX_BITS (IDX_BITS),
    .PPN_W    (PPN_W)
  ) u_pages (
    .clk    (clk),
    .wr_en  (refill_valid),
    .wr_idx (rf_idx),
    .wr_ppn (refill_ppn),
    .rd_idx (lk_idx),
    .rd_ppn (lk_ppn)
  );

  assign sel_hit = way_hit[lk_way];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      flags_q     <= '0;
      paddr_q     <= '0;
      vaddr_q     <= '0;
      kind_q      <= '0;
    end else if (accept) begin
      rsp_valid_q    <= 1'b1;
      vaddr_q        <= req_vaddr;
      kind_q         <= req_kind;
      flags_q.ld_mis <= ld_trap;
      flags_q.st_mis <= st_trap;
      flags_q.hit    <= !(ld_trap || st_trap) && sel_hit;
      flags_q.miss   <= !(ld_trap || st_trap) && !sel_hit;
      if (!(ld_trap || st_trap) && sel_hit)
        paddr_q <= {lk_ppn, req_vaddr[PAGE_BITS-1:0]};
      else
        paddr_q <= '0;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptbr_q  <= '0;
      fault_q <= '0;
    end else begin
      if (ptbr_we) ptbr_q <= ptbr_wdata & ~OFF_MASK;
      if (accept && (ld_trap || st_trap)) fault_q <= req_vaddr;
    end
  end

  assign rsp_valid       = rsp_valid_q;
  assign rsp_hit         = flags_q.hit;
  assign rsp_miss        = flags_q.miss;
  assign rsp_ld_misalign = flags_q.ld_mis;
  assign rsp_st_misalign = flags_q.st_mis;
  assign rsp_paddr       = paddr_q;
  assign rsp_vaddr       = vaddr_q;
  assign rsp_kind        = kind_q;
  assign ptbr            = ptbr_q;
  assign fault_vaddr     = fault_q;

  assert_no_take_during_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_valid || ptbr_we) |-> !req_ready);

  assert_rsp_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_vaddr)
                                   && $stable(flags_q)));

  assert_one_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_hit, rsp_miss, rsp_ld_misalign, rsp_st_misalign}));

  assert_fetch_never_traps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == KIND_FETCH) |-> !(rsp_ld_misalign || rsp_st_misalign));

  assert_fault_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && (ld_trap || st_trap)) |=> $stable(fault_vaddr));

  assert_ptbr_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ptbr_we |=> ((ptbr & OFF_MASK) == '0));

endmodule

// File: tb/tlb_xlate_bench.sv
module tlb_xlate_bench;

  localparam int ENT = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic [1:0]  req_size = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic        rsp_hit, rsp_miss, rsp_ld_misalign, rsp_st_misalign;
  logic [31:0] rsp_paddr, rsp_vaddr;
  logic [1:0]  rsp_kind;
  logic        refill_valid = 1'b0;
  logic [19:0] refill_vpn = '0;
  logic [1:0]  refill_kind = '0;
  logic [19:0] refill_ppn = '0;
  logic        ptbr_we = 1'b0;
  logic [31:0] ptbr_wdata = '0;
  logic [31:0] ptbr;
  logic [31:0] fault_vaddr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Model state
  bit          mv   [3][ENT];
  logic [15:0] mtag [3][ENT];
  logic [19:0] mdata[ENT];
  logic [31:0] mbad = '0;

  always #5 clk = ~clk;

  tlb_xlate #(.ADDR_W(32), .PA_W(32), .PAGE_BITS(12), .ENTRIES(ENT)) u_tlb_xlate (
    .clk, .rst_n, .req_valid, .req_ready, .req_vaddr, .req_kind, .req_size,
    .rsp_valid, .rsp_ready, .rsp_hit, .rsp_miss, .rsp_ld_misalign, .rsp_st_misalign,
    .rsp_paddr, .rsp_vaddr, .rsp_kind, .refill_valid, .refill_vpn, .refill_kind,
    .refill_ppn, .ptbr_we, .ptbr_wdata, .ptbr, .fault_vaddr
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic int wayof(input logic [1:0] k);
    return (k == 2'd0) ? 0 : (k == 2'd2) ? 2 : 1;
  endfunction

  task automatic do_req(input logic [31:0] va, input logic [1:0] k,
                        input logic [1:0] s, input string rq);
    int w = wayof(k);
    int idx = int'(va[15:12]);
    bit mis = (k != 2'd0) && ((va[2:0] & 3'((1 << s) - 1)) != 3'd0);
    bit eh = !mis && mv[w][idx] && (mtag[w][idx] == va[31:16]);
    logic [31:0] ep = eh ? {mdata[idx], va[11:0]} : 32'd0;
    logic [31:0] held;
    if (mis) mbad = va;
    @(negedge clk);
    req_vaddr = va; req_kind = k; req_size = s; req_valid = 1'b1; rsp_ready = 1'b0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1, rq, "rsp_valid", {31'd0, rsp_valid}, 32'd1);
    chk(rsp_hit === eh, rq, "hit", {31'd0, rsp_hit}, {31'd0, eh});
    chk(rsp_miss === (!mis && !eh), rq, "miss", {31'd0, rsp_miss}, {31'd0, !mis && !eh});
    chk(rsp_ld_misalign === (mis && w == 1), rq, "ld_misalign",
        {31'd0, rsp_ld_misalign}, {31'd0, mis && w == 1});
    chk(rsp_st_misalign === (mis && w == 2), rq, "st_misalign",
        {31'd0, rsp_st_misalign}, {31'd0, mis && w == 2});
    chk(rsp_paddr === ep, rq, "paddr", rsp_paddr, ep);
    chk(rsp_vaddr === va, "R5", "rsp_vaddr", rsp_vaddr, va);
    chk(fault_vaddr === mbad, "R9", "fault_vaddr", fault_vaddr, mbad);
    held = rsp_paddr;
    @(negedge clk);
    chk(rsp_valid === 1'b1 && rsp_paddr === held, "R2", "held paddr", rsp_paddr, held);
    chk(req_ready === 1'b0, "R2", "ready while pending", {31'd0, req_ready}, 32'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic do_refill(input logic [31:0] va, input logic [1:0] k, input logic [19:0] ppn);
    int idx = int'(va[15:12]);
    int w = wayof(k);
    @(negedge clk);
    refill_valid = 1'b1; refill_vpn = va[31:12]; refill_kind = k; refill_ppn = ppn;
    #1;
    chk(req_ready === 1'b0, "R2", "ready during refill", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    refill_valid = 1'b0;
    mdata[idx] = ppn;
    for (int j = 0; j < 3; j++) mv[j][idx] = (j == w);
    mtag[w][idx] = va[31:16];
  endtask

  initial begin
    for (int j = 0; j < 3; j++)
      for (int i = 0; i < ENT; i++) begin mv[j][i] = 0; mtag[j][i] = '0; end
    for (int i = 0; i < ENT; i++) mdata[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(rsp_valid === 1'b0, "R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk(req_ready === 1'b1, "R1", "req_ready", {31'd0, req_ready}, 32'd1);
    chk(ptbr === 32'd0, "R1", "ptbr", ptbr, 32'd0);
    chk(fault_vaddr === 32'd0, "R1", "fault_vaddr", fault_vaddr, 32'd0);
    for (int k = 0; k < 4; k++)
      for (int i = 0; i < ENT; i++)
        do_req({16'h1234, 4'(i), 12'h000}, 2'(k), 2'd2, "R1");

    // R6 R7 R4: fill each slot per kind, probe the page with every kind
    for (int k = 0; k < 3; k++)
      for (int i = 0; i < ENT; i++) begin
        logic [31:0] va = {16'hA000 + 16'(k * 16'h0111 + i), 4'(i), 12'h000};
        do_refill(va, 2'(k), 20'h50000 | 20'(k << 8) | 20'(i));
        for (int q = 0; q < 4; q++)
          do_req(va | 32'h0000_07F8, 2'(q), 2'd3, "R6");
      end
    // R3: full sweep of final table state with shifted offsets
    for (int q = 0; q < 3; q++)
      for (int i = 0; i < ENT; i++) begin
        do_req({16'hA222 + 16'(i), 4'(i), 12'hABC} & 32'hFFFF_FFFC, 2'(q), 2'd2, "R3");
        do_req({16'hA223 + 16'(i), 4'(i), 12'h010}, 2'(q), 2'd0, "R3");
      end
    // R7: refill of another kind drops the first kind's tag
    do_refill(32'h0BEE_F000, 2'd1, 20'h0C0DE);
    do_req(32'h0BEE_F123, 2'd1, 2'd0, "R4");
    do_refill(32'h0BEE_F000, 2'd2, 20'h0D00D);
    do_req(32'h0BEE_F123, 2'd1, 2'd0, "R7");
    do_req(32'h0BEE_F124, 2'd2, 2'd2, "R7");
    // R11: same index, different tag evicts
    do_refill(32'h1111_5000, 2'd0, 20'h11111);
    do_req(32'h2222_5004, 2'd0, 2'd2, "R11");
    do_refill(32'h2222_5000, 2'd0, 20'h22222);
    do_req(32'h1111_5004, 2'd0, 2'd2, "R11");
    do_req(32'h2222_5004, 2'd0, 2'd2, "R11");
    // R8 R9: size x low-bit sweep for every kind
    for (int k = 0; k < 4; k++)
      for (int s = 0; s < 4; s++)
        for (int lo = 0; lo < 8; lo++)
          do_req(32'h0000_3000 | 32'(k << 4) | 32'(lo), 2'(k), 2'(s), "R8");
    // R10: page-table base write flushes everything
    do_refill(32'h3333_7000, 2'd1, 20'h77777);
    do_req(32'h3333_7008, 2'd1, 2'd3, "R4");
    @(negedge clk);
    ptbr_we = 1'b1; ptbr_wdata = 32'h1234_5ABC;
    #1;
    chk(req_ready === 1'b0, "R2", "ready during ptbr write", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    ptbr_we = 1'b0;
    for (int j = 0; j < 3; j++)
      for (int i = 0; i < ENT; i++) mv[j][i] = 0;
    chk(ptbr === 32'h1234_5000, "R10", "ptbr", ptbr, 32'h1234_5000);
    do_req(32'h3333_7008, 2'd1, 2'd3, "R10");
    for (int q = 0; q < 3; q++)
      for (int i = 0; i < ENT; i++)
        do_req({16'hA222 + 16'(i), 4'(i), 12'h000}, 2'(q), 2'd0, "R10");

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule